// File: doc/BRIEF.md
# Device Controller Command Responder

This block is the command front end of a device controller that sits on a processor I/O bus. The bus carries a start strobe together with a device number and a 3-bit command code. The controller answers only when the number matches the value it was built with. A test command returns an acknowledge pulse with a 16-bit status word on the bus. A start command raises a request toward the selector channel control logic, and the acknowledge is held back until the channel answers that request.

Status bit 0 reports whether a start command can be accepted now: the device must be ready and the selector channel must be idle. The upper status bits carry device status inputs through a build-time mask, and masked-off bits read as zero. The controller acts once per strobe rising edge. It ignores new commands while a channel request is outstanding. It drives the bus only in the acknowledge cycle of a test command.

Top module: `devctl_cmd_resp`

## Requirements
- R1: A command is taken only on a rising edge of `start_strobe_i` with `dev_sel_i` equal to the `DEV_ID` parameter. With any other number, none of `resp_ack_o`, `resp_drive_o` or `chan_req_o` rises.
- R2: A matching test command (code 3'b001) sampled at a clock edge gives `resp_ack_o` and `resp_drive_o` high for exactly the one cycle after that edge, with the status word on `resp_data_o`.
- R3: Status bit 0 is 1 exactly when `dev_ready_i` is 1 and `chan_active_i` is 0, as sampled at the command edge.
- R4: Status bits 15..1 equal `dev_status_i` ANDed with `STATUS_MASK`, with `dev_status_i[i]` placed in bit i+1. With the default mask 15'h00FF, bits 15..9 always read zero.
- R5: A matching start command (code 3'b000) raises `chan_req_o` in the cycle after the command edge. It gives no acknowledge at that point.
- R6: `chan_req_o` stays high until `chan_grant_i` is sampled high. In the next cycle `chan_req_o` is low and `resp_ack_o` is high for one cycle, with `resp_drive_o` low.
- R7: A matching command with any other code gives a one-cycle `resp_ack_o`, with `resp_drive_o` low, data zero and no request.
- R8: `resp_data_o` is zero whenever `resp_drive_o` is low, and `resp_drive_o` is high only together with `resp_ack_o`.
- R9: A strobe held high for several cycles produces a single response.
- R10: Commands that arrive while `chan_req_o` is high are ignored. No acknowledge appears until the grant.
- R11: A low `rst_ni` clears `resp_ack_o`, `resp_drive_o`, `resp_data_o` and `chan_req_o` at once and returns the block to idle. Release passes through a two-flop synchronizer, and a strobe already high at release is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_strobe_i | input | 1 | Command start strobe from the bus |
| dev_sel_i | input | DEV_W | Device number on the bus |
| cmd_code_i | input | 3 | Command code (000 start, 001 test) |
| dev_ready_i | input | 1 | Device ready |
| chan_active_i | input | 1 | Selector channel busy |
| dev_status_i | input | DATA_W-1 | Device status for word bits 15..1 |
| chan_grant_i | input | 1 | Selector channel answer to the request |
| resp_ack_o | output | 1 | Acknowledge pulse back to the bus |
| resp_drive_o | output | 1 | Bus data drive enable |
| resp_data_o | output | DATA_W | Status word, zero when not driven |
| chan_req_o | output | 1 | Request to the selector channel |

## Verification
The bench targets device numbers that differ from the wired one by a single bit. A comparator that ignored a bit would answer there. It holds the strobe high for several cycles, which exposes a design that re-triggers on the level. It also sends test commands while a start request is pending, which a design that forgot the wait would acknowledge early. It checks bit 0 under every combination of ready and channel busy, and it sets the masked upper status bits, so a wrong polarity or a leaking mask shows up as a wrong word. A reset in the middle of a pending request must drop the request at once.

// File: rtl/devctl_pkg.sv
package devctl_pkg;
  localparam int unsigned CMD_W = 3;
  localparam logic [CMD_W-1:0] CMD_START = 3'b000;
  localparam logic [CMD_W-1:0] CMD_TEST  = 3'b001;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } resp_state_e;
endpackage

// File: rtl/devctl_rst_sync.sv
module devctl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/devctl_decode.sv
module devctl_decode
  import devctl_pkg::*;
#(
  parameter int unsigned    DEV_W  = 4,
  parameter logic [DEV_W-1:0] DEV_ID = 4'd5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic [DEV_W-1:0] dev_sel_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             fire_test_o,
  output logic             fire_start_o,
  output logic             fire_other_o
);
  logic strobe_q;
  logic strobe_d;
  logic sel_hit;
  logic strobe_edge;
  logic fire;

  always_comb begin
    strobe_d = strobe_i;
  end

  // Reset value 1: a strobe that is already high at release is not an edge.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b1;
    else         strobe_q <= strobe_d;
  end

  always_comb begin
    sel_hit      = (dev_sel_i == DEV_ID);
    strobe_edge  = strobe_i && !strobe_q;
    fire         = strobe_edge && sel_hit;
    fire_test_o  = fire && (cmd_i == CMD_TEST);
    fire_start_o = fire && (cmd_i == CMD_START);
    fire_other_o = fire && (cmd_i != CMD_TEST) && (cmd_i != CMD_START);
  end

  // R9: a command fires only when the strobe was low in the previous cycle.
  p_single_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_test_o || fire_start_o || fire_other_o) |-> !$past(strobe_i));
endmodule

// File: rtl/devctl_status.sv
module devctl_status #(
  parameter int unsigned DATA_W = 16,
  parameter logic [DATA_W-2:0] STATUS_MASK = 15'h00FF
) (
  input  logic              dev_ready_i,
  input  logic              chan_active_i,
  input  logic [DATA_W-2:0] dev_status_i,
  output logic [DATA_W-1:0] word_o
);
  logic start_ok;
  logic [DATA_W-2:0] upper;

  always_comb begin
    start_ok = dev_ready_i && !chan_active_i;
  end

  for (genvar i = 0; i < DATA_W - 1; i++) begin : g_bit
    if (STATUS_MASK[i]) begin : g_used
      assign upper[i] = dev_status_i[i];
    end else begin : g_unused
      assign upper[i] = 1'b0;
    end
  end

  assign word_o = {upper, start_ok};

  // R3: the start-ok bit is never set while the channel is busy.
  always_comb begin
    a_ok_busy_r3: assert (!(chan_active_i && word_o[0]));
  end
endmodule

// File: rtl/devctl_seq.sv
module devctl_seq
  import devctl_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_test_i,
  input  logic              fire_start_i,
  input  logic              fire_other_i,
  input  logic              grant_i,
  input  logic [DATA_W-1:0] status_i,
  output logic              ack_o,
  output logic              drive_o,
  output logic [DATA_W-1:0] data_o,
  output logic              req_o
);
  resp_state_e       state_q, state_d;
  logic              ack_q, ack_d;
  logic              drive_q, drive_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              req_q, req_d;

  always_comb begin
    state_d = state_q;
    ack_d   = 1'b0;
    drive_d = 1'b0;
    data_d  = '0;
    req_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (fire_test_i) begin
          ack_d   = 1'b1;
          drive_d = 1'b1;
          data_d  = status_i;
        end else if (fire_start_i) begin
          req_d   = 1'b1;
          state_d = ST_WAIT;
        end else if (fire_other_i) begin
          ack_d   = 1'b1;
        end
      end
      ST_WAIT: begin
        if (grant_i) begin
          ack_d   = 1'b1;
          state_d = ST_IDLE;
        end else begin
          req_d   = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
      drive_q <= 1'b0;
      data_q  <= '0;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
      drive_q <= drive_d;
      data_q  <= data_d;
      req_q   <= req_d;
    end
  end

  assign ack_o   = ack_q;
  assign drive_o = drive_q;
  assign data_o  = data_q;
  assign req_o   = req_q;

  // R6: the request holds until the grant arrives.
  p_req_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !grant_i) |=> req_o);
  // R6: the grant drops the request and yields one acknowledge without drive.
  p_grant_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && grant_i) |=> (!req_o && ack_o && !drive_o));
  // R10: a command during a pending request is not acknowledged.
  p_wait_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !grant_i && (fire_test_i || fire_other_i)) |=> !ack_o);
  // R1: no acknowledge or request appears without a decoded command or grant.
  p_no_spurious_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_o && !fire_test_i && !fire_start_i && !fire_other_i) |=> (!ack_o && !req_o));
endmodule

// File: rtl/devctl_cmd_resp.sv
module devctl_cmd_resp
  import devctl_pkg::*;
#(
  parameter int unsigned       DEV_W       = 4,
  parameter logic [DEV_W-1:0]  DEV_ID      = 4'd5,
  parameter int unsigned       DATA_W      = 16,
  parameter logic [DATA_W-2:0] STATUS_MASK = 15'h00FF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_strobe_i,
  input  logic [DEV_W-1:0]  dev_sel_i,
  input  logic [2:0]        cmd_code_i,
  input  logic              dev_ready_i,
  input  logic              chan_active_i,
  input  logic [DATA_W-2:0] dev_status_i,
  input  logic              chan_grant_i,
  output logic              resp_ack_o,
  output logic              resp_drive_o,
  output logic [DATA_W-1:0] resp_data_o,
  output logic              chan_req_o
);
  logic              rst_s_n;
  logic              fire_test;
  logic              fire_start;
  logic              fire_other;
  logic [DATA_W-1:0] status_word;

  devctl_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_s_n)
  );

  devctl_decode #(.DEV_W(DEV_W), .DEV_ID(DEV_ID)) u_decode (
    .clk_i        (clk_i),
    .rst_ni       (rst_s_n),
    .strobe_i     (start_strobe_i),
    .dev_sel_i    (dev_sel_i),
    .cmd_i        (cmd_code_i),
    .fire_test_o  (fire_test),
    .fire_start_o (fire_start),
    .fire_other_o (fire_other)
  );

  devctl_status #(.DATA_W(DATA_W), .STATUS_MASK(STATUS_MASK)) u_status (
    .dev_ready_i   (dev_ready_i),
    .chan_active_i (chan_active_i),
    .dev_status_i  (dev_status_i),
    .word_o        (status_word)
  );

  devctl_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_s_n),
    .fire_test_i  (fire_test),
    .fire_start_i (fire_start),
    .fire_other_i (fire_other),
    .grant_i      (chan_grant_i),
    .status_i     (status_word),
    .ack_o        (resp_ack_o),
    .drive_o      (resp_drive_o),
    .data_o       (resp_data_o),
    .req_o        (chan_req_o)
  );

  // R8: drive only with acknowledge, data quiet otherwise.
  p_drive_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    resp_drive_o |-> resp_ack_o);
  p_data_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    !resp_drive_o |-> (resp_data_o == '0));
  // R3: driven bit 0 reflects ready and channel state at the command edge.
  p_start_ok_r3: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    resp_drive_o |-> (resp_data_o[0] == $past(dev_ready_i && !chan_active_i)));
  // R4: masked-off status bits never appear on the bus.
  p_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (resp_data_o[DATA_W-1:1] & ~STATUS_MASK) == '0);
endmodule

// File: tb/devctl_cmd_resp_tb.sv
module devctl_cmd_resp_tb;
  localparam int unsigned DEV_W  = 4;
  localparam logic [3:0]  DEV_ID = 4'd5;
  localparam int unsigned DATA_W = 16;
  localparam logic [14:0] MASK   = 15'h00FF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        strobe;
  logic [3:0]  dev_sel;
  logic [2:0]  cmd;
  logic        ready, busy, grant;
  logic [14:0] dstat;
  logic        ack, drive, req;
  logic [15:0] data;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  devctl_cmd_resp #(.DEV_W(DEV_W), .DEV_ID(DEV_ID), .DATA_W(DATA_W), .STATUS_MASK(MASK)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_strobe_i(strobe), .dev_sel_i(dev_sel),
    .cmd_code_i(cmd), .dev_ready_i(ready), .chan_active_i(busy), .dev_status_i(dstat),
    .chan_grant_i(grant), .resp_ack_o(ack), .resp_drive_o(drive), .resp_data_o(data),
    .chan_req_o(req)
  );

  function automatic logic [15:0] exp_word(logic rdy, logic bsy, logic [14:0] st);
    return {st & MASK, rdy & ~bsy};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic chk_out(input string rq, input logic ea, input logic ed,
                         input logic [15:0] edat, input logic er);
    chk(ack == ea,    rq, "ack",   ack,   ea);
    chk(drive == ed,  rq, "drive", drive, ed);
    chk(data == edat, rq, "data",  data,  edat);
    chk(req == er,    rq, "req",   req,   er);
  endtask

  // Pulse strobe for one cycle; returns at the negedge after the sampling edge.
  task automatic issue(input logic [3:0] ds, input logic [2:0] c, input logic r,
                       input logic b, input logic [14:0] s);
    dev_sel = ds; cmd = c; ready = r; busy = b; dstat = s; strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_grant();
    grant = 1'b1;
    @(negedge clk);
    grant = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; strobe = 1'b0; dev_sel = '0; cmd = '0;
    ready = 1'b0; busy = 1'b0; grant = 1'b0; dstat = '0;
    idle_cycles(3);
    chk_out("R11", 1'b0, 1'b0, 16'h0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    idle_cycles(4);
    chk_out("R11", 1'b0, 1'b0, 16'h0, 1'b0);

    // R2/R3/R4: test command, upper unused status bits set
    issue(DEV_ID, 3'b001, 1'b1, 1'b0, 15'h7FFF);
    chk_out("R2", 1'b1, 1'b1, exp_word(1'b1, 1'b0, 15'h7FFF), 1'b0);
    chk(data[15:9] == 7'h0, "R4", "unused bits", data[15:9], 0);
    @(negedge clk);
    chk_out("R2", 1'b0, 1'b0, 16'h0, 1'b0);

    // R3: every ready/busy combination
    for (int k = 0; k < 4; k++) begin
      issue(DEV_ID, 3'b001, k[0], k[1], 15'h00A5);
      chk(data[0] == (k[0] & ~k[1]), "R3", "start-ok bit", data[0], k[0] & ~k[1]);
      @(negedge clk);
    end

    // R1: single-bit neighbours of the wired number
    for (int b = 0; b < 4; b++) begin
      issue(DEV_ID ^ (4'b1 << b), 3'b001, 1'b1, 1'b0, 15'h1);
      chk_out("R1", 1'b0, 1'b0, 16'h0, 1'b0);
      issue(DEV_ID ^ (4'b1 << b), 3'b000, 1'b1, 1'b0, 15'h1);
      chk_out("R1", 1'b0, 1'b0, 16'h0, 1'b0);
      @(negedge clk);
    end

    // R5/R6: start command, grant after three cycles
    issue(DEV_ID, 3'b000, 1'b1, 1'b0, 15'h3);
    chk_out("R5", 1'b0, 1'b0, 16'h0, 1'b1);
    idle_cycles(3);
    chk_out("R6", 1'b0, 1'b0, 16'h0, 1'b1);
    do_grant();
    chk_out("R6", 1'b1, 1'b0, 16'h0, 1'b0);
    @(negedge clk);
    chk_out("R6", 1'b0, 1'b0, 16'h0, 1'b0);

    // R10: commands during a pending request are ignored
    issue(DEV_ID, 3'b000, 1'b1, 1'b0, 15'h0);
    @(negedge clk);
    issue(DEV_ID, 3'b001, 1'b1, 1'b0, 15'h0F);
    chk_out("R10", 1'b0, 1'b0, 16'h0, 1'b1);
    @(negedge clk);
    issue(DEV_ID, 3'b101, 1'b1, 1'b0, 15'h0F);
    chk_out("R10", 1'b0, 1'b0, 16'h0, 1'b1);
    do_grant();
    chk_out("R10", 1'b1, 1'b0, 16'h0, 1'b0);
    @(negedge clk);

    // R7: other codes
    for (int c = 2; c < 8; c++) begin
      issue(DEV_ID, 3'(c), 1'b1, 1'b0, 15'h7F);
      chk_out("R7", 1'b1, 1'b0, 16'h0, 1'b0);
      @(negedge clk);
    end

    // R9: strobe held high for five cycles gives one response
    dev_sel = DEV_ID; cmd = 3'b001; ready = 1'b1; busy = 1'b0; dstat = 15'h11; strobe = 1'b1;
    @(negedge clk);
    chk(ack == 1'b1, "R9", "first ack", ack, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(ack == 1'b0, "R9", "repeat ack", ack, 0);
    end
    strobe = 1'b0;
    idle_cycles(2);

    // R11: reset during a pending request; strobe high at release is not taken
    issue(DEV_ID, 3'b000, 1'b1, 1'b0, 15'h0);
    chk(req == 1'b1, "R11", "req before reset", req, 1);
    #1 rst_n = 1'b0;
    #0.5;
    chk_out("R11", 1'b0, 1'b0, 16'h0, 1'b0);
    @(negedge clk);
    dev_sel = DEV_ID; cmd = 3'b001; strobe = 1'b1;
    rst_n = 1'b1;
    idle_cycles(4);
    chk_out("R11", 1'b0, 1'b0, 16'h0, 1'b0);
    strobe = 1'b0;
    idle_cycles(2);

    // Random mix against the bench model
    for (int it = 0; it < 300; it++) begin
      logic [3:0]  ds;
      logic [2:0]  c;
      logic        r, b;
      logic [14:0] s;
      int          dly;
      ds  = ($urandom % 2) ? DEV_ID : 4'($urandom);
      c   = ($urandom % 3 == 0) ? 3'($urandom) : 3'($urandom % 2);
      r   = 1'($urandom); b = 1'($urandom); s = 15'($urandom);
      dly = $urandom % 5;
      issue(ds, c, r, b, s);
      if (ds != DEV_ID) begin
        chk_out("R1", 1'b0, 1'b0, 16'h0, 1'b0);
      end else if (c == 3'b001) begin
        chk_out("R2", 1'b1, 1'b1, exp_word(r, b, s), 1'b0);
      end else if (c == 3'b000) begin
        chk_out("R5", 1'b0, 1'b0, 16'h0, 1'b1);
        idle_cycles(dly);
        chk(req == 1'b1, "R6", "req held", req, 1);
        do_grant();
        chk_out("R6", 1'b1, 1'b0, 16'h0, 1'b0);
      end else begin
        chk_out("R7", 1'b1, 1'b0, 16'h0, 1'b0);
      end
      @(negedge clk);
      chk_out("R8", 1'b0, 1'b0, 16'h0, 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule